// File: doc/BRIEF.md
# Addressed Serial Quad Converter Register Front End

This block is the digital input side of a four-channel, 12-bit converter. A host sends 16-bit words over a three-wire serial link made of an active-low frame strobe, a serial clock and a data line. Each word carries a 12-bit code, a 2-bit device address and a 2-bit channel select. When the address in the word equals the two strap inputs, the code is written into the input register of the chosen channel. Every word shifted in also leaves on a serial output, so several devices can share one host link in a chain.

Each channel is double buffered. Codes written over the link wait in the input registers and reach the converter registers only while the load strobe is low, so all four outputs change together. A clear strobe zeroes the converter registers and leaves the input registers intact, so a later load brings the earlier codes back. All pins are sampled by a system clock that runs at least four times faster than the serial clock.

Top module: `qdac_serial_front`

## Requirements
- R1: A word is sent MSB first. Bits 15..4 hold the 12-bit code, bit 3 is compared with `addr_strap[1]`, bit 2 is compared with `addr_strap[0]`, and bits 1..0 select the channel.
- R2: Channel select 0, 1, 2 and 3 pick channel A, B, C and D. Channel k appears on `dac_words[12*k+11 : 12*k]`.
- R3: While `fsync_n` is low, each falling edge of `sclk` shifts in one bit. The write happens on the sixteenth falling edge. If `fsync_n` goes high before that edge, the bit count resets and nothing is written.
- R4: A word whose address bits differ from the straps changes no input register.
- R5: `sdo` shows the bit that entered sixteen falling edges earlier. This holds for every word, whether or not its address matched.
- R6: Falling edges after the sixteenth in the same frame keep shifting toward `sdo` but trigger no second write.
- R7: While `load_n` is low, all four converter registers take the contents of their input registers.
- R8: While `clear_n` is low, all converter registers are zero. The input registers keep their contents.
- R9: When `clear_n` and `load_n` are both low, clear wins.
- R10: After reset, all input and converter registers are zero, `sdo` is 0 and no frame is in progress.
- R11: While `load_n` is high and `clear_n` is high, the converter registers do not change, even when words are written.
- R12: A pin change shows at the outputs within five system clocks. The serial clock period must be at least four system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples all pins |
| rst | input | 1 | Synchronous reset, active high |
| fsync_n | input | 1 | Frame strobe, active low |
| sclk | input | 1 | Serial clock; data is taken on its falling edge |
| sdi | input | 1 | Serial data in |
| addr_strap | input | 2 | Device address straps |
| load_n | input | 1 | Level-sensitive load of all converter registers, active low |
| clear_n | input | 1 | Level-sensitive zeroing of converter registers, active low |
| sdo | output | 1 | Chain output: last stage of the shift register |
| dac_words | output | 48 | Four 12-bit converter register values, channel A in the low bits |

## Verification
The link is driven with four kinds of frame:
- Full frames whose address matches, one to each channel. These expose any mix-up of field positions or channel decode.
- A full frame whose address does not match. This separates the address filter from plain shifting.
- A frame cut short after ten bits, which tests the write trigger.
- A frame stretched to twenty bits, which shows that the write fires once while the chain output keeps moving.

Load and clear are used in several ways: load alone, clear alone, both low together, and load held low during a write. Together these show the double buffering, that clear keeps the input registers, and which strobe takes priority. The straps are changed partway through the run, so the address compare is tried with more than one value.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
    localparam int DATA_W  = 12;
    localparam int ADDR_W  = 2;
    localparam int SEL_W   = 2;
    localparam int FRAME_W = DATA_W + ADDR_W + SEL_W;
    localparam int CH_N    = 1 << SEL_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    // Field order inside a received word, MSB first on the wire
    typedef struct packed {
        logic [DATA_W-1:0] code;
        logic [ADDR_W-1:0] addr;
        logic [SEL_W-1:0]  sel;
    } frame_t;

    // Synchronised pin bundle
    typedef struct packed {
        logic fs_n;
        logic sck;
        logic sd;
        logic ld_n;
        logic clr_n;
    } pins_t;

    localparam pins_t PINS_IDLE = '{fs_n: 1'b1, sck: 1'b0, sd: 1'b0, ld_n: 1'b1, clr_n: 1'b1};

    function automatic logic addr_hit(frame_t f, logic [ADDR_W-1:0] strap);
        return f.addr == strap;
    endfunction
endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
    parameter int            W      = 1,
    parameter int            STAGES = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/qdac_shifter.sv
module qdac_shifter
    import qdac_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               fs_act,
    input  logic               sck_s,
    input  logic               sd_s,
    output logic [FRAME_W-1:0] sreg,
    output logic [CNT_W-1:0]   bit_cnt,
    output logic               wr_stb
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

    logic sck_q;
    logic fall;

    assign fall = sck_q & ~sck_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q   <= 1'b0;
            sreg    <= '0;
            bit_cnt <= '0;
            wr_stb  <= 1'b0;
        end else begin
            sck_q  <= sck_s;
            wr_stb <= 1'b0;
            if (!fs_act) begin
                bit_cnt <= '0;
            end else if (fall) begin
                sreg <= {sreg[FRAME_W-2:0], sd_s};
                if (bit_cnt != FULL) bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == LAST) wr_stb <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/qdac_latches.sv
module qdac_latches
    import qdac_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_stb,
    input  frame_t                 frm,
    input  logic [ADDR_W-1:0]      strap,
    input  logic                   ld_act,
    input  logic                   clr_act,
    output logic [CH_N*DATA_W-1:0] in_words,
    output logic [CH_N*DATA_W-1:0] dac_words
);
    logic hit;
    assign hit = wr_stb && addr_hit(frm, strap);

    for (genvar g = 0; g < CH_N; g++) begin : g_ch
        logic [DATA_W-1:0] in_q;
        logic [DATA_W-1:0] dac_q;

        always_ff @(posedge clk) begin
            if (rst)                                in_q <= '0;
            else if (hit && frm.sel == SEL_W'(g))   in_q <= frm.code;
        end

        always_ff @(posedge clk) begin
            if (rst)          dac_q <= '0;
            else if (clr_act) dac_q <= '0;
            else if (ld_act)  dac_q <= in_q;
        end

        assign in_words[g*DATA_W +: DATA_W]  = in_q;
        assign dac_words[g*DATA_W +: DATA_W] = dac_q;
    end
endmodule

// File: rtl/qdac_serial_front.sv
module qdac_serial_front
    import qdac_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   fsync_n,
    input  logic                   sclk,
    input  logic                   sdi,
    input  logic [ADDR_W-1:0]      addr_strap,
    input  logic                   load_n,
    input  logic                   clear_n,
    output logic                   sdo,
    output logic [CH_N*DATA_W-1:0] dac_words
);
    pins_t               raw, syn;
    logic                fs_act, ld_act, clr_act, wr_stb;
    logic [FRAME_W-1:0]  sreg;
    logic [CNT_W-1:0]    bit_cnt;
    frame_t              frm;
    logic [CH_N*DATA_W-1:0] in_words;

    assign raw = '{fs_n: fsync_n, sck: sclk, sd: sdi, ld_n: load_n, clr_n: clear_n};

    qdac_sync #(.W($bits(pins_t)), .STAGES(SYNC_STAGES), .RST_VAL(PINS_IDLE)) u_sync (
        .clk(clk), .rst(rst), .d(raw), .q(syn)
    );

    assign fs_act  = ~syn.fs_n;
    assign ld_act  = ~syn.ld_n;
    assign clr_act = ~syn.clr_n;

    qdac_shifter u_shift (
        .clk(clk), .rst(rst), .fs_act(fs_act), .sck_s(syn.sck), .sd_s(syn.sd),
        .sreg(sreg), .bit_cnt(bit_cnt), .wr_stb(wr_stb)
    );

    assign frm = frame_t'(sreg);
    assign sdo = sreg[FRAME_W-1];

    qdac_latches u_lat (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .frm(frm), .strap(addr_strap),
        .ld_act(ld_act), .clr_act(clr_act), .in_words(in_words), .dac_words(dac_words)
    );
endmodule

// File: rtl/qdac_serial_front_chk.sv
module qdac_serial_front_chk
    import qdac_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   fs_act,
    input logic                   ld_act,
    input logic                   clr_act,
    input logic                   wr_stb,
    input logic [CNT_W-1:0]       bit_cnt,
    input frame_t                 frm,
    input logic [ADDR_W-1:0]      addr_strap,
    input logic [CH_N*DATA_W-1:0] in_words,
    input logic [CH_N*DATA_W-1:0] dac_words
);
    p_clear_zero_r8: assert property (@(posedge clk) disable iff (rst)
        clr_act |=> dac_words == '0);

    p_clear_wins_r9: assert property (@(posedge clk) disable iff (rst)
        (clr_act && ld_act) |=> dac_words == '0);

    p_load_copy_r7: assert property (@(posedge clk) disable iff (rst)
        (ld_act && !clr_act) |=> dac_words == $past(in_words));

    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (!ld_act && !clr_act) |=> $stable(dac_words));

    p_write_at_full_r3: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> bit_cnt == CNT_W'(FRAME_W));

    p_abort_clears_r3: assert property (@(posedge clk) disable iff (rst)
        !fs_act |=> bit_cnt == '0);

    p_miss_no_write_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && frm.addr != addr_strap) |=> $stable(in_words));

    p_single_write_r6: assert property (@(posedge clk) disable iff (rst)
        (fs_act && bit_cnt == CNT_W'(FRAME_W)) |=> !wr_stb);
endmodule

bind qdac_serial_front qdac_serial_front_chk u_chk (
    .clk(clk), .rst(rst), .fs_act(fs_act), .ld_act(ld_act), .clr_act(clr_act),
    .wr_stb(wr_stb), .bit_cnt(bit_cnt), .frm(frm), .addr_strap(addr_strap),
    .in_words(in_words), .dac_words(dac_words)
);

// File: tb/qdac_serial_front_bench.sv
`timescale 1ns/1ps
module qdac_serial_front_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fsync_n = 1'b1, sclk = 1'b0, sdi = 1'b0, load_n = 1'b1, clear_n = 1'b1;
    logic [1:0]  addr_strap = 2'b01;
    logic        sdo;
    logic [47:0] dac_words;

    always #5 clk = ~clk;

    qdac_serial_front u_qdac_serial_front (
        .clk(clk), .rst(rst), .fsync_n(fsync_n), .sclk(sclk), .sdi(sdi),
        .addr_strap(addr_strap), .load_n(load_n), .clear_n(clear_n),
        .sdo(sdo), .dac_words(dac_words)
    );

    int tests = 0, fails = 0;
    int cyc = 0, last_change = 0;
    bit done = 0;
    string cur_req = "R10";

    // Behavioural reference state
    logic [15:0] m_sh = '0;
    int          m_cnt = 0;
    logic [11:0] m_in  [4] = '{default: '0};
    logic [11:0] m_dac [4] = '{default: '0};

    localparam int HALF = 6;  // R12: serial clock period 12 system clocks

    always @(posedge clk) cyc <= cyc + 1;

    task automatic report_check(string req, string what, logic [15:0] act, logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Compare outputs against the model on every settled clock
    always @(negedge clk) begin
        if (!rst && !done && (cyc - last_change) >= 5) begin
            for (int k = 0; k < 4; k++) begin
                if (!clear_n)     m_dac[k] = '0;
                else if (!load_n) m_dac[k] = m_in[k];
            end
            for (int k = 0; k < 4; k++)
                report_check(cur_req, $sformatf("ch%0d", k),
                             {4'h0, dac_words[k*12 +: 12]}, {4'h0, m_dac[k]});
            report_check("R5", "sdo", {15'h0, sdo}, {15'h0, m_sh[15]});
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic mark();
        last_change = cyc;
    endtask

    task automatic model_fall(logic b);
        m_sh = {m_sh[14:0], b};
        if (m_cnt < 16) begin
            m_cnt++;
            // R1 field positions, R2 channel decode, R3 write on 16th edge
            if (m_cnt == 16 && m_sh[3:2] == addr_strap)
                m_in[m_sh[1:0]] = m_sh[15:4];
        end
    endtask

    task automatic send(logic [31:0] v, int nbits);
        fsync_n = 1'b0; mark(); tick(HALF);
        for (int i = 0; i < nbits; i++) begin
            sclk = 1'b1; sdi = v[nbits-1-i]; mark(); tick(HALF);
            sclk = 1'b0; model_fall(sdi); mark(); tick(HALF);
        end
        fsync_n = 1'b1; m_cnt = 0; mark(); tick(HALF);
    endtask

    function automatic logic [15:0] word(logic [11:0] d, logic [1:0] a, logic [1:0] s);
        return {d, a, s};
    endfunction

    task automatic pulse_load();
        load_n = 1'b0; mark(); tick(10);
        load_n = 1'b1; mark(); tick(8);
    endtask

    initial begin
        tick(5);
        rst = 1'b0;
        tick(1);
        // R10 reset state
        for (int k = 0; k < 4; k++)
            report_check("R10", "reset ch", {4'h0, dac_words[k*12 +: 12]}, 16'h0);
        report_check("R10", "reset sdo", {15'h0, sdo}, 16'h0);
        mark(); tick(6);

        cur_req = "R11";  // writes held back while load high
        send({16'h0, word(12'h123, 2'b01, 2'd0)}, 16);
        send({16'h0, word(12'hABC, 2'b01, 2'd1)}, 16);
        send({16'h0, word(12'h800, 2'b01, 2'd2)}, 16);
        send({16'h0, word(12'hFFF, 2'b01, 2'd3)}, 16);

        cur_req = "R7";   // also R1 and R2 field placement
        pulse_load();

        cur_req = "R4";
        send({16'h0, word(12'h555, 2'b10, 2'd0)}, 16);
        pulse_load();

        cur_req = "R3";   // aborted frame
        send({22'h0, word(12'h0AA, 2'b01, 2'd2) >> 6}, 10);
        pulse_load();

        cur_req = "R6";   // overlong frame
        send({12'h0, word(12'h3C3, 2'b01, 2'd1), 4'b1010}, 20);
        pulse_load();

        cur_req = "R8";
        clear_n = 1'b0; mark(); tick(10);
        clear_n = 1'b1; mark(); tick(8);
        pulse_load();

        cur_req = "R9";
        clear_n = 1'b0; load_n = 1'b0; mark(); tick(12);
        clear_n = 1'b1; mark(); tick(10);
        load_n = 1'b1; mark(); tick(8);

        cur_req = "R7";   // transparent while load held low
        load_n = 1'b0; mark(); tick(8);
        send({16'h0, word(12'h0F0, 2'b01, 2'd3)}, 16);
        load_n = 1'b1; mark(); tick(8);

        cur_req = "R1";   // different strap value
        addr_strap = 2'b10; mark(); tick(8);
        send({16'h0, word(12'h777, 2'b10, 2'd2)}, 16);
        send({16'h0, word(12'h111, 2'b01, 2'd0)}, 16);
        pulse_load();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL R12 watchdog actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule